// File: doc/BRIEF.md
# Reference Clock Timing Scaler with Standby Power Control

This block derives every slow timing event of a small control computer from one reference clock. A two-step binary prescaler produces a processor clock enable at half the reference rate and a square-wave master-frequency sync at a quarter of it. A one-hot ring of five positions then divides the master frequency by five. A chain of binary stages follows. With a 2.048 MHz reference and the default seventeen stages, the first stage runs at 51.2 kHz and the last at 0.78125 Hz. Every stage is a clock enable in the reference domain. Each stage reports its rising transition as a single-cycle pulse.

Two stage pulses are used inside the block. A low-rate tap becomes a periodic increment request for the counter logic of the core. The slowest tap wakes the core while it is in standby. A small power controller drives the core power enable. A powered core can report that its work is finished while the standby-allowed switch is set, and the controller then removes power. On the next wake tap it restores power and issues a one-cycle wake pulse. If the switch is clear, the core simply stays powered. The prescaler and the stages keep running throughout standby.

Top module: `timing_scaler`

## Requirements
- R1: After a synchronous reset is released, `proc_en` is high in every second cycle, starting with the first cycle after the first clock edge. Counting the clock edges since release as n, `proc_en` equals n mod 2.
- R2: `mf_sync` is a square wave with a period of four cycles, equal to bit 1 of n. It can change only on an edge at which `proc_en` was high.
- R3: `ring_pulse` is high for one cycle whenever n is a nonzero multiple of 20. That is once per five master-frequency periods.
- R4: Bit j-1 of `stage_pulse` (stage j, counted from 1) is high for one cycle when n is a multiple of 20 and (n/20) mod 2^j equals 2^(j-1). At most one bit of `stage_pulse` is high in any cycle.
- R5: The divide-by-five ring always holds exactly one set bit. An illegal pattern is replaced by the start pattern on its next step, so ring pulses stay evenly spaced, ten in every 200 cycles.
- R6: `inc_req` repeats the pulse of stage INC_TAP while `core_pwr_en` is high. It stays low while the core is powered down.
- R7: While powered, a cycle with both `core_done` and `standby_allowed` high clears `core_pwr_en` from the next cycle on.
- R8: While powered down, a pulse of stage WAKE_TAP sets `core_pwr_en` in the next cycle. In that same cycle `core_wake` is high for exactly one cycle.
- R9: `core_done` with `standby_allowed` low leaves the core powered. A WAKE_TAP pulse while powered leaves `core_wake` low.
- R10: While `rst` is high at a clock edge, the next cycle shows `proc_en`, `mf_sync`, `ring_pulse`, `stage_pulse` and `core_wake` low and `core_pwr_en` high, whatever the power state was. Counting restarts from n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| standby_allowed | input | 1 | Switch permitting the core to be powered down |
| core_done | input | 1 | Core reports its current work finished |
| proc_en | output | 1 | Processor clock enable, half reference rate |
| mf_sync | output | 1 | Master-frequency square wave, quarter reference rate |
| ring_pulse | output | 1 | One-cycle pulse at each divide-by-five wrap |
| stage_pulse | output | NUM_STAGES | One-cycle rising-transition pulse per binary stage |
| inc_req | output | 1 | Periodic counter increment request from stage INC_TAP |
| core_pwr_en | output | 1 | Core power enable |
| core_wake | output | 1 | One-cycle wake pulse when power is restored |

## Verification
`proc_en` and `mf_sync` follow the edge count directly. `ring_pulse` and every stage pulse are registered at the same edge that completes a twenty-cycle group, so they appear in the cycle whose edge count is the multiple of 20. A power change appears one cycle after the edge that sampled `core_done` or the wake tap, and `core_wake` appears in that same cycle. The bench keeps its own edge counter from reset release and drives stimulus only at falling edges. It samples each result at the falling edge of the cycle predicted above, so it never reads a value in the cycle of its own update.

// File: rtl/timing_scaler_pkg.sv
package timing_scaler_pkg;

    // Length of the one-hot divide-by-five ring
    localparam int RING_STAGES = 5;

    // Power state of the core
    typedef enum logic {
        PWR_ON   = 1'b0,
        PWR_DOWN = 1'b1
    } pwr_state_e;

    // Fast enables produced by the two-step prescaler
    typedef struct packed {
        logic proc_en;   // half reference rate
        logic mf_level;  // quarter-rate square wave
        logic mf_step;   // one cycle per master-frequency period
    } prescale_t;

    // True when exactly one bit of the vector is set
    function automatic logic single_bit(input logic [31:0] v);
        int ones;
        ones = 0;
        for (int i = 0; i < 32; i++) begin
            ones += int'(v[i]);
        end
        return (ones == 1);
    endfunction

endpackage

// File: rtl/ts_prescale.sv
module ts_prescale
    import timing_scaler_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output prescale_t ticks
);

    logic half_q;
    logic quarter_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            quarter_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                quarter_q <= ~quarter_q;
            end
        end
    end

    assign ticks.proc_en  = half_q;
    assign ticks.mf_level = quarter_q;
    assign ticks.mf_step  = half_q & quarter_q;

    // R1: processor enable alternates every cycle
    a_r1_proc_drop: assert property (@(posedge clk) disable iff (rst)
        half_q |=> !half_q);
    a_r1_proc_rise: assert property (@(posedge clk) disable iff (rst)
        !half_q |=> half_q);
    // R2: master-frequency level moves only after an enabled cycle
    a_r2_mf_hold: assert property (@(posedge clk) disable iff (rst)
        !half_q |=> $stable(quarter_q));

endmodule

// File: rtl/ts_ring.sv
module ts_ring
    import timing_scaler_pkg::*;
#(
    parameter int LEN = RING_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic wrap,
    output logic ring_pulse
);

    localparam logic [LEN-1:0] HOME = LEN'(1);

    logic [LEN-1:0] ring_q;
    logic [LEN-1:0] ring_d;

    always_comb begin
        if (single_bit(32'(ring_q))) begin
            ring_d = {ring_q[LEN-2:0], ring_q[LEN-1]};
        end else begin
            ring_d = HOME;
        end
    end

    assign wrap = step & ring_q[LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q     <= HOME;
            ring_pulse <= 1'b0;
        end else begin
            if (step) begin
                ring_q <= ring_d;
            end
            ring_pulse <= wrap;
        end
    end

    // R5: the ring always holds a single set bit
    a_r5_ring_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(ring_q));
    // R3: a wrap pulse never lasts two cycles
    a_r3_ring_single: assert property (@(posedge clk) disable iff (rst)
        ring_pulse |=> !ring_pulse);

endmodule

// File: rtl/ts_cascade.sv
module ts_cascade #(
    parameter int STAGES = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [STAGES-1:0] stage_pulse
);

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] rise;

    // A stage rises when every lower stage is set and it is clear
    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        if (j == 0) begin : g_first
            assign rise[j] = advance & ~cnt_q[0];
        end else begin : g_upper
            assign rise[j] = advance & (&cnt_q[j-1:0]) & ~cnt_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            stage_pulse <= '0;
        end else begin
            if (advance) begin
                cnt_q <= cnt_q + 1'b1;
            end
            stage_pulse <= rise;
        end
    end

    // R4: at most one stage reports a rising transition per cycle
    a_r4_one_stage: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_pulse));

endmodule

// File: rtl/ts_standby.sv
module ts_standby
    import timing_scaler_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake_tick,
    input  logic standby_allowed,
    input  logic core_done,
    output logic core_pwr_en,
    output logic core_wake
);

    pwr_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PWR_ON;
            core_wake <= 1'b0;
        end else begin
            core_wake <= 1'b0;
            unique case (st_q)
                PWR_ON: begin
                    if (core_done && standby_allowed) begin
                        st_q <= PWR_DOWN;
                    end
                end
                PWR_DOWN: begin
                    if (wake_tick) begin
                        st_q      <= PWR_ON;
                        core_wake <= 1'b1;
                    end
                end
                default: st_q <= PWR_ON;
            endcase
        end
    end

    assign core_pwr_en = (st_q == PWR_ON);

    // R7: finished work with standby allowed removes power
    a_r7_power_down: assert property (@(posedge clk) disable iff (rst)
        (core_pwr_en && core_done && standby_allowed) |=> !core_pwr_en);
    // R8: a wake tap in standby restores power with a wake pulse
    a_r8_wake_up: assert property (@(posedge clk) disable iff (rst)
        (!core_pwr_en && wake_tick) |=> (core_pwr_en && core_wake));
    // R9: without permission the core stays powered
    a_r9_stay_on: assert property (@(posedge clk) disable iff (rst)
        (core_pwr_en && !standby_allowed) |=> core_pwr_en);
    // R10: reset returns power on with no wake pulse
    a_r10_reset_on: assert property (@(posedge clk)
        rst |=> (core_pwr_en && !core_wake));

endmodule

// File: rtl/timing_scaler.sv
module timing_scaler
    import timing_scaler_pkg::*;
#(
    parameter int NUM_STAGES = 17,
    parameter int INC_TAP    = 10,
    parameter int WAKE_TAP   = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  standby_allowed,
    input  logic                  core_done,
    output logic                  proc_en,
    output logic                  mf_sync,
    output logic                  ring_pulse,
    output logic [NUM_STAGES-1:0] stage_pulse,
    output logic                  inc_req,
    output logic                  core_pwr_en,
    output logic                  core_wake
);

    localparam int INC_IDX  = INC_TAP - 1;
    localparam int WAKE_IDX = WAKE_TAP - 1;

    prescale_t ticks;
    logic      ring_wrap;

    ts_prescale u_prescale (
        .clk   (clk),
        .rst   (rst),
        .ticks (ticks)
    );

    ts_ring #(.LEN(RING_STAGES)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .step       (ticks.mf_step),
        .wrap       (ring_wrap),
        .ring_pulse (ring_pulse)
    );

    ts_cascade #(.STAGES(NUM_STAGES)) u_cascade (
        .clk         (clk),
        .rst         (rst),
        .advance     (ring_wrap),
        .stage_pulse (stage_pulse)
    );

    ts_standby u_standby (
        .clk             (clk),
        .rst             (rst),
        .wake_tick       (stage_pulse[WAKE_IDX]),
        .standby_allowed (standby_allowed),
        .core_done       (core_done),
        .core_pwr_en     (core_pwr_en),
        .core_wake       (core_wake)
    );

    assign proc_en = ticks.proc_en;
    assign mf_sync = ticks.mf_level;
    assign inc_req = stage_pulse[INC_IDX] & core_pwr_en;

    // R3/R4: a stage pulse only ever accompanies a ring wrap pulse
    a_r4_stage_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (|stage_pulse) |-> ring_pulse);

endmodule

// File: tb/timing_scaler_test.sv
module timing_scaler_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_ST       = 4;
    localparam int N_VEC      = 13;

    // {edge count, proc_en, mf_sync, ring_pulse, stage_pulse[3:0], inc_req}
    localparam logic [23:0] VEC [N_VEC] = '{
        {16'd1,   1'b1, 1'b0, 1'b0, 4'b0000, 1'b0},
        {16'd2,   1'b0, 1'b1, 1'b0, 4'b0000, 1'b0},
        {16'd3,   1'b1, 1'b1, 1'b0, 4'b0000, 1'b0},
        {16'd4,   1'b0, 1'b0, 1'b0, 4'b0000, 1'b0},
        {16'd19,  1'b1, 1'b1, 1'b0, 4'b0000, 1'b0},
        {16'd20,  1'b0, 1'b0, 1'b1, 4'b0001, 1'b0},
        {16'd40,  1'b0, 1'b0, 1'b1, 4'b0010, 1'b1},
        {16'd41,  1'b1, 1'b0, 1'b0, 4'b0000, 1'b0},
        {16'd60,  1'b0, 1'b0, 1'b1, 4'b0001, 1'b0},
        {16'd80,  1'b0, 1'b0, 1'b1, 4'b0100, 1'b0},
        {16'd160, 1'b0, 1'b0, 1'b1, 4'b1000, 1'b0},
        {16'd162, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0},
        {16'd200, 1'b0, 1'b0, 1'b1, 4'b0010, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            standby_allowed = 1'b0;
    logic            core_done = 1'b0;
    logic            proc_en;
    logic            mf_sync;
    logic            ring_pulse;
    logic [N_ST-1:0] stage_pulse;
    logic            inc_req;
    logic            core_pwr_en;
    logic            core_wake;

    int n_edges = 0;
    int checks  = 0;
    int fails   = 0;

    timing_scaler #(.NUM_STAGES(N_ST), .INC_TAP(2), .WAKE_TAP(4)) uut (
        .clk             (clk),
        .rst             (rst),
        .standby_allowed (standby_allowed),
        .core_done       (core_done),
        .proc_en         (proc_en),
        .mf_sync         (mf_sync),
        .ring_pulse      (ring_pulse),
        .stage_pulse     (stage_pulse),
        .inc_req         (inc_req),
        .core_pwr_en     (core_pwr_en),
        .core_wake       (core_wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge count since reset release, kept by the bench
    always @(posedge clk) begin
        if (rst) n_edges <= 0;
        else     n_edges <= n_edges + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at n=%0d: actual=%0h expected=%0h", tag, n_edges, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        @(negedge clk);
        while (n_edges != k) @(negedge clk);
    endtask

    task automatic check_reset_state();
        check("R10 proc_en", 32'(proc_en), 0);
        check("R10 mf_sync", 32'(mf_sync), 0);
        check("R10 ring_pulse", 32'(ring_pulse), 0);
        check("R10 stage_pulse", 32'(stage_pulse), 0);
        check("R10 core_pwr_en", 32'(core_pwr_en), 1);
        check("R10 core_wake", 32'(core_wake), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired at n=%0d", n_edges);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int pulses;
        // Reset state (R10)
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        // Vector walk: R1, R2, R3, R4, R6 with the core powered
        for (int i = 0; i < N_VEC; i++) begin
            wait_n(int'(VEC[i][23:8]));
            check("R1 proc_en", 32'(proc_en), 32'(VEC[i][7]));
            check("R2 mf_sync", 32'(mf_sync), 32'(VEC[i][6]));
            check("R3 ring_pulse", 32'(ring_pulse), 32'(VEC[i][5]));
            check("R4 stage_pulse", 32'(stage_pulse), 32'(VEC[i][4:1]));
            check("R6 inc_req", 32'(inc_req), 32'(VEC[i][0]));
        end

        // R5: ring pulses stay evenly spaced, ten per 200 cycles
        pulses = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (ring_pulse) pulses++;
        end
        check("R5 ring pulse count", 32'(pulses), 10);

        // Restart for standby sequence
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        standby_allowed = 1'b1;

        wait_n(5);
        core_done = 1'b1;
        wait_n(6);
        core_done = 1'b0;
        check("R7 power down", 32'(core_pwr_en), 0);
        check("R7 no wake", 32'(core_wake), 0);

        wait_n(40);
        check("R6 tap present", 32'(stage_pulse[1]), 1);
        check("R6 inc_req gated", 32'(inc_req), 0);

        wait_n(160);
        check("R8 still down", 32'(core_pwr_en), 0);
        wait_n(161);
        check("R8 power restored", 32'(core_pwr_en), 1);
        check("R8 wake pulse", 32'(core_wake), 1);
        wait_n(162);
        check("R8 wake one cycle", 32'(core_wake), 0);

        wait_n(200);
        check("R6 inc_req awake", 32'(inc_req), 1);

        wait_n(205);
        core_done = 1'b1;
        wait_n(206);
        core_done = 1'b0;
        check("R7 power down again", 32'(core_pwr_en), 0);

        wait_n(481);
        check("R8 second wake power", 32'(core_pwr_en), 1);
        check("R8 second wake pulse", 32'(core_wake), 1);
        standby_allowed = 1'b0;

        wait_n(490);
        core_done = 1'b1;
        wait_n(491);
        core_done = 1'b0;
        check("R9 stays powered", 32'(core_pwr_en), 1);

        wait_n(800);
        check("R9 wake tap present", 32'(stage_pulse[3]), 1);
        wait_n(801);
        check("R9 no wake when on", 32'(core_wake), 0);
        check("R9 power kept", 32'(core_pwr_en), 1);

        standby_allowed = 1'b1;
        wait_n(805);
        core_done = 1'b1;
        wait_n(806);
        core_done = 1'b0;
        check("R7 asleep before reset", 32'(core_pwr_en), 0);

        // R10: reset from standby powers the core back on
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        wait_n(1);
        check("R10 restart proc_en", 32'(proc_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule